// File: doc/BRIEF.md
# Self-Programming Flash Command Controller

This block lets a small processor core reprogram its own on-chip flash. Software writes a command byte into a control register. A valid command opens a short window. A store strobe or a load strobe that falls inside the window runs the command, using the Z address and the 16-bit data word as operands. Store-side commands are: fill one word of a temporary page buffer, erase a page, commit the buffer into a page, release the busy application section, and program boot lock bits. Load-side commands return fuse, lock or signature bytes. A load strobe with no armed command reads the flash array directly.

Erase and write take a fixed number of cycles. During that time the enable bit in the control register stays high, so software can poll it. A separate section-busy flag hides the flash contents from plain reads until software releases the section. An interrupt request is raised whenever interrupts are enabled and no command is armed or running. A page-select register supplies the address bits above the 16-bit Z value.

Top module: `selfprog_flash_ctrl`

## Requirements
- R1: Control register bits are: 0 enable, 1 page erase, 2 page write, 3 lock set, 4 section re-enable, 5 signature read, 6 section busy (read-only), 7 interrupt enable. A write with bit 0 set and at most one of bits 5..1 set arms that command, and the readback shows enable plus the command bit. Enable alone arms a buffer fill. Any other pattern arms nothing and reads back with bits 5..0 clear.
- R2: An armed command runs only for a strobe in one of the four cycles that follow the register write. After those four cycles it is dropped, enable reads 0, and a later strobe acts as if nothing were armed.
- R3: A fill stores data_i into the page-buffer word selected by the Z word address. The stored word becomes visible once a page write commits it.
- R4: A page write keeps enable high for WRITE_CYCLES cycles, then copies the page buffer into the addressed page and resets every buffer word to 16'hFFFF.
- R5: A page erase keeps enable high for ERASE_CYCLES cycles, then sets every word of the addressed page to 16'hFFFF.
- R6: Starting an erase or a write sets the section-busy bit. While it is set, plain loads return 8'hFF. Only a section re-enable store clears it.
- R7: A lock-set store takes data_i[5:2] as the lock bits and ignores Z. A 0 bit programs the matching lock bit, and a programmed lock bit never returns to 1. Lock bits reset to 4'b1111.
- R8: A lock-set command followed by a load returns a byte chosen by Z[1:0]: 0 low fuse, 1 lock byte {2'b11, lock[3:0], 2'b11}, 2 extended fuse, 3 high fuse.
- R9: A signature-read command followed by a load returns signature byte Z[1:0] (0, 1, 2 are the low, middle and high bytes of SIG_ROW), and 8'hFF for index 3.
- R10: irq_o is high exactly when interrupt enable is set and enable reads 0.
- R11: The full byte address is {page select, Z}. Fills, erases and writes aimed beyond the flash leave the array unchanged, and loads there return 8'hFF.
- R12: While an erase or write runs, control writes change only the interrupt-enable bit.
- R13: A plain load returns the byte at Z (the low byte of the word when Z[0] is 0, the high byte when it is 1) on rdata_o in the cycle after the strobe, with rdata_valid_o high for that one cycle.
- R14: After reset, ctrl_rdata_o, rdata_o, rdata_valid_o and irq_o are 0 and the flash reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| ctrl_rdata_o | output | 8 | Control register readback |
| page_sel_we_i | input | 1 | Page-select register write strobe |
| page_sel_i | input | PSEL_W | Upper address bits above Z |
| store_i | input | 1 | Store-program-memory strobe |
| load_i | input | 1 | Load-program-memory strobe |
| z_i | input | 16 | Z byte address |
| data_i | input | 16 | Data word operand |
| rdata_o | output | 8 | Load result byte |
| rdata_valid_o | output | 1 | Load result valid |
| irq_o | output | 1 | Ready interrupt request |

## Verification
The assertions check on every cycle that:
- the interrupt request follows the enable and interrupt-enable bits;
- enable is never still high four cycles after a register write unless an erase or write is running;
- section busy falls only after a store strobe and rises only with enable high;
- lock bits never change from programmed to unprogrammed;
- read-valid follows each load strobe by exactly one cycle.

Only the bench scenarios can show data movement: buffer words landing in the right page, the buffer clearing after a commit, the exact erase and write latencies, and fuse, lock and signature bytes selected by Z. The bench scenarios also cover the window edge at the fourth and fifth cycles and the page-select register pushing an address out of range.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int BIT_EN    = 0;
  localparam int BIT_ERASE = 1;
  localparam int BIT_WRITE = 2;
  localparam int BIT_LOCK  = 3;
  localparam int BIT_RWWEN = 4;
  localparam int BIT_SIG   = 5;
  localparam int BIT_RWWSB = 6;
  localparam int BIT_IE    = 7;

  typedef enum logic [2:0] {
    OP_NONE, OP_FILL, OP_ERASE, OP_WRITE, OP_RWWEN, OP_LOCK, OP_SIG
  } op_e;

  function automatic op_e decode_cmd(input logic [7:0] v);
    if (!v[BIT_EN]) return OP_NONE;
    case (v[5:1])
      5'b00000: return OP_FILL;
      5'b00001: return OP_ERASE;
      5'b00010: return OP_WRITE;
      5'b00100: return OP_LOCK;
      5'b01000: return OP_RWWEN;
      5'b10000: return OP_SIG;
      default:  return OP_NONE;
    endcase
  endfunction

  function automatic logic [4:0] op_bits(input op_e op);
    case (op)
      OP_ERASE: return 5'b00001;
      OP_WRITE: return 5'b00010;
      OP_LOCK:  return 5'b00100;
      OP_RWWEN: return 5'b01000;
      OP_SIG:   return 5'b10000;
      default:  return 5'b00000;
    endcase
  endfunction
endpackage

// File: rtl/sfc_cmd_unit.sv
module sfc_cmd_unit import sfc_pkg::*; #(
  parameter int ARM_CYCLES   = 4,
  parameter int ERASE_CYCLES = 6,
  parameter int WRITE_CYCLES = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctrl_we_i,
  input  logic [7:0] ctrl_wdata_i,
  input  logic       store_i,
  input  logic       load_i,
  output op_e        st_op_o,
  output op_e        ld_op_o,
  output logic       commit_erase_o,
  output logic       commit_write_o,
  output logic       rwwsb_o,
  output logic [7:0] ctrl_rdata_o,
  output logic       irq_o
);
  localparam int WIN_W    = $clog2(ARM_CYCLES + 1);
  localparam int BUSY_MAX = (ERASE_CYCLES > WRITE_CYCLES) ? ERASE_CYCLES : WRITE_CYCLES;
  localparam int BUSY_W   = $clog2(BUSY_MAX + 1);

  op_e               cmd_q;
  logic [WIN_W-1:0]  win_q;
  logic [BUSY_W-1:0] busy_q;
  logic              kind_wr_q, ie_q, rwwsb_q;
  logic              armed, busy, en;
  logic [4:0]        shown;
  op_e               new_cmd;
  logic              unused_w;

  assign unused_w = ctrl_wdata_i[BIT_RWWSB];
  assign armed    = (win_q != '0);
  assign busy     = (busy_q != '0);
  assign new_cmd  = decode_cmd(ctrl_wdata_i);
  assign st_op_o  = (armed && store_i) ? cmd_q : OP_NONE;
  assign ld_op_o  = (armed && load_i)  ? cmd_q : OP_NONE;
  assign commit_erase_o = (busy_q == BUSY_W'(1)) && !kind_wr_q;
  assign commit_write_o = (busy_q == BUSY_W'(1)) && kind_wr_q;

  // arming window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= OP_NONE;
      win_q <= '0;
      ie_q  <= 1'b0;
    end else if (ctrl_we_i) begin
      ie_q <= ctrl_wdata_i[BIT_IE];
      if (!busy) begin
        cmd_q <= new_cmd;
        win_q <= (new_cmd == OP_NONE) ? '0 : WIN_W'(ARM_CYCLES);
      end
    end else if (armed) begin
      if (store_i || load_i) begin
        win_q <= '0;
        cmd_q <= OP_NONE;
      end else begin
        win_q <= win_q - WIN_W'(1);
        if (win_q == WIN_W'(1)) cmd_q <= OP_NONE;
      end
    end
  end

  // long-operation timer and section busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= '0;
      kind_wr_q <= 1'b0;
      rwwsb_q   <= 1'b0;
    end else begin
      if (st_op_o == OP_ERASE) begin
        busy_q    <= BUSY_W'(ERASE_CYCLES);
        kind_wr_q <= 1'b0;
        rwwsb_q   <= 1'b1;
      end else if (st_op_o == OP_WRITE) begin
        busy_q    <= BUSY_W'(WRITE_CYCLES);
        kind_wr_q <= 1'b1;
        rwwsb_q   <= 1'b1;
      end else begin
        if (busy) busy_q <= busy_q - BUSY_W'(1);
        if (st_op_o == OP_RWWEN) rwwsb_q <= 1'b0;
      end
    end
  end

  assign en    = armed || busy;
  assign shown = busy  ? op_bits(kind_wr_q ? OP_WRITE : OP_ERASE)
               : armed ? op_bits(cmd_q) : 5'b00000;
  assign ctrl_rdata_o = {ie_q, rwwsb_q, shown, en};
  assign rwwsb_o      = rwwsb_q;
  assign irq_o        = ie_q && !en;
endmodule

// File: rtl/sfc_page_buf.sv
module sfc_page_buf #(
  parameter int PAGE_WORDS = 8,
  parameter int DATA_W     = 16,
  localparam int OFF_W     = $clog2(PAGE_WORDS)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               fill_i,
  input  logic [OFF_W-1:0]                   idx_i,
  input  logic [DATA_W-1:0]                  data_i,
  input  logic                               clear_i,
  output logic [PAGE_WORDS-1:0][DATA_W-1:0]  words_o
);
  for (genvar w = 0; w < PAGE_WORDS; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   word_q <= '1;
      else if (clear_i)                              word_q <= '1;
      else if (fill_i && (idx_i == OFF_W'(w)))       word_q <= data_i;
    end
    assign words_o[w] = word_q;
  end
endmodule

// File: rtl/sfc_flash_array.sv
module sfc_flash_array #(
  parameter int PAGE_WORDS = 8,
  parameter int NUM_PAGES  = 8,
  parameter int DATA_W     = 16,
  localparam int OFF_W     = $clog2(PAGE_WORDS),
  localparam int PG_W      = $clog2(NUM_PAGES)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              erase_i,
  input  logic                              write_i,
  input  logic [PG_W-1:0]                   page_i,
  input  logic [PAGE_WORDS-1:0][DATA_W-1:0] page_data_i,
  input  logic [PG_W-1:0]                   rd_page_i,
  input  logic [OFF_W-1:0]                  rd_off_i,
  output logic [DATA_W-1:0]                 rd_data_o
);
  logic [PAGE_WORDS-1:0][DATA_W-1:0] pages_w [NUM_PAGES];

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    logic [PAGE_WORDS-1:0][DATA_W-1:0] page_q;
    logic sel;
    assign sel = (page_i == PG_W'(p));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              page_q <= '1;
      else if (erase_i && sel)  page_q <= '1;
      else if (write_i && sel)  page_q <= page_data_i;
    end
    assign pages_w[p] = page_q;
  end

  assign rd_data_o = pages_w[rd_page_i][rd_off_i];
endmodule

// File: rtl/selfprog_flash_ctrl.sv
module selfprog_flash_ctrl import sfc_pkg::*; #(
  parameter int          PAGE_WORDS   = 8,
  parameter int          NUM_PAGES    = 8,
  parameter int          ARM_CYCLES   = 4,
  parameter int          ERASE_CYCLES = 6,
  parameter int          WRITE_CYCLES = 10,
  parameter int          PSEL_W       = 8,
  parameter logic [7:0]  LOW_FUSE     = 8'h62,
  parameter logic [7:0]  HIGH_FUSE    = 8'hD9,
  parameter logic [7:0]  EXT_FUSE     = 8'hF7,
  parameter logic [23:0] SIG_ROW      = 24'hA15C3E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_wdata_i,
  output logic [7:0]        ctrl_rdata_o,
  input  logic              page_sel_we_i,
  input  logic [PSEL_W-1:0] page_sel_i,
  input  logic              store_i,
  input  logic              load_i,
  input  logic [15:0]       z_i,
  input  logic [15:0]       data_i,
  output logic [7:0]        rdata_o,
  output logic              rdata_valid_o,
  output logic              irq_o
);
  localparam int OFF_W       = $clog2(PAGE_WORDS);
  localparam int PG_W        = $clog2(NUM_PAGES);
  localparam int WORD_AW     = OFF_W + PG_W;
  localparam int FULL_W      = 16 + PSEL_W;
  localparam int FLASH_BYTES = 2 * PAGE_WORDS * NUM_PAGES;

  op_e                              st_op, ld_op;
  logic                             commit_erase, commit_write, rwwsb;
  logic [PSEL_W-1:0]                psel_q;
  logic [FULL_W-1:0]                full_addr;
  logic                             in_range;
  logic [OFF_W-1:0]                 off;
  logic [PG_W-1:0]                  page;
  logic [PG_W-1:0]                  pend_page_q;
  logic                             pend_ok_q;
  logic [3:0]                       lock_q;
  logic [PAGE_WORDS-1:0][15:0]      buf_words;
  logic [15:0]                      flash_word;
  logic [7:0]                       rd_byte, rdata_d, rdata_q;
  logic                             valid_q;

  sfc_cmd_unit #(
    .ARM_CYCLES  (ARM_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) u_cmd (
    .clk_i, .rst_ni, .ctrl_we_i, .ctrl_wdata_i, .store_i, .load_i,
    .st_op_o       (st_op),
    .ld_op_o       (ld_op),
    .commit_erase_o(commit_erase),
    .commit_write_o(commit_write),
    .rwwsb_o       (rwwsb),
    .ctrl_rdata_o,
    .irq_o
  );

  // address extension
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            psel_q <= '0;
    else if (page_sel_we_i) psel_q <= page_sel_i;
  end

  assign full_addr = {psel_q, z_i};
  assign in_range  = (full_addr < FULL_W'(FLASH_BYTES));
  assign off       = full_addr[OFF_W:1];
  assign page      = full_addr[WORD_AW:OFF_W+1];

  // target of the running erase/write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_page_q <= '0;
      pend_ok_q   <= 1'b0;
    end else if (st_op == OP_ERASE || st_op == OP_WRITE) begin
      pend_page_q <= page;
      pend_ok_q   <= in_range;
    end
  end

  sfc_page_buf #(.PAGE_WORDS(PAGE_WORDS), .DATA_W(16)) u_buf (
    .clk_i, .rst_ni,
    .fill_i (st_op == OP_FILL && in_range),
    .idx_i  (off),
    .data_i (data_i),
    .clear_i(commit_write),
    .words_o(buf_words)
  );

  sfc_flash_array #(.PAGE_WORDS(PAGE_WORDS), .NUM_PAGES(NUM_PAGES), .DATA_W(16)) u_array (
    .clk_i, .rst_ni,
    .erase_i    (commit_erase && pend_ok_q),
    .write_i    (commit_write && pend_ok_q),
    .page_i     (pend_page_q),
    .page_data_i(buf_words),
    .rd_page_i  (page),
    .rd_off_i   (off),
    .rd_data_o  (flash_word)
  );

  // boot lock bits: one-way programming
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lock_q <= 4'hF;
    else if (st_op == OP_LOCK)  lock_q <= lock_q & data_i[5:2];
  end

  assign rd_byte = z_i[0] ? flash_word[15:8] : flash_word[7:0];

  always_comb begin
    case (ld_op)
      OP_LOCK: begin
        case (z_i[1:0])
          2'd0:    rdata_d = LOW_FUSE;
          2'd1:    rdata_d = {2'b11, lock_q, 2'b11};
          2'd2:    rdata_d = EXT_FUSE;
          default: rdata_d = HIGH_FUSE;
        endcase
      end
      OP_SIG: begin
        case (z_i[1:0])
          2'd0:    rdata_d = SIG_ROW[7:0];
          2'd1:    rdata_d = SIG_ROW[15:8];
          2'd2:    rdata_d = SIG_ROW[23:16];
          default: rdata_d = 8'hFF;
        endcase
      end
      default: rdata_d = (rwwsb || !in_range) ? 8'hFF : rd_byte;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= load_i;
      if (load_i) rdata_q <= rdata_d;
    end
  end

  assign rdata_o       = rdata_q;
  assign rdata_valid_o = valid_q;
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
  parameter int ARM_CYCLES = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ctrl_we_i,
  input logic [7:0] ctrl_rdata_o,
  input logic       store_i,
  input logic       load_i,
  input logic       rdata_valid_o,
  input logic       irq_o,
  input logic [3:0] lock_q
);
  logic [7:0] since_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 since_we <= 8'hFF;
    else if (ctrl_we_i)          since_we <= 8'd0;
    else if (since_we != 8'hFF)  since_we <= since_we + 8'd1;
  end

  // R10
  a_r10_irq_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (ctrl_rdata_o[7] && !ctrl_rdata_o[0]));

  // R2
  a_r2_window_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_we >= 8'(ARM_CYCLES) && ctrl_rdata_o[2:1] == 2'b00) |-> !ctrl_rdata_o[0]);

  // R6
  a_r6_busy_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_rdata_o[6]) |-> $past(store_i));

  // R6
  a_r6_busy_with_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_rdata_o[6]) |-> ctrl_rdata_o[0]);

  // R7
  a_r7_lock_one_way: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((lock_q & ~$past(lock_q)) == 4'h0));

  // R13
  a_r13_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> rdata_valid_o);

  // R13
  a_r13_valid_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> !rdata_valid_o);
endmodule

bind selfprog_flash_ctrl sfc_checker #(.ARM_CYCLES(ARM_CYCLES)) u_chk (
  .clk_i, .rst_ni, .ctrl_we_i, .ctrl_rdata_o, .store_i, .load_i,
  .rdata_valid_o, .irq_o, .lock_q(lock_q)
);

// File: tb/selfprog_flash_ctrl_tb.sv
`timescale 1ns/1ps
module selfprog_flash_ctrl_tb;
  localparam int ERASE_CYC = 6;
  localparam int WRITE_CYC = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [7:0]  ctrl_wdata = '0;
  logic [7:0]  ctrl_rdata;
  logic        psel_we = 1'b0;
  logic [7:0]  psel = '0;
  logic        store = 1'b0;
  logic        load = 1'b0;
  logic [15:0] z = '0;
  logic [15:0] data = '0;
  logic [7:0]  rdata;
  logic        rvalid, irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  selfprog_flash_ctrl #(.ERASE_CYCLES(ERASE_CYC), .WRITE_CYCLES(WRITE_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .ctrl_rdata_o(ctrl_rdata), .page_sel_we_i(psel_we), .page_sel_i(psel),
    .store_i(store), .load_i(load), .z_i(z), .data_i(data),
    .rdata_o(rdata), .rdata_valid_o(rvalid), .irq_o(irq)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic arm(input logic [7:0] c);
    ctrl_we = 1'b1; ctrl_wdata = c;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic do_store(input logic [7:0] c, input int gap, input logic [15:0] zz, input logic [15:0] d);
    arm(c);
    repeat (gap) @(negedge clk);
    store = 1'b1; z = zz; data = d;
    @(negedge clk);
    store = 1'b0;
  endtask

  task automatic plain_load(input logic [15:0] zz, output logic [7:0] b);
    load = 1'b1; z = zz;
    @(negedge clk);
    load = 1'b0;
    b = rdata;
  endtask

  task automatic do_load(input logic [7:0] c, input int gap, input logic [15:0] zz, output logic [7:0] b);
    arm(c);
    repeat (gap) @(negedge clk);
    plain_load(zz, b);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (ctrl_rdata[0] && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // {ctrl, gap, z, expected byte, requirement number}
  localparam int NV = 10;
  localparam logic [42:0] VEC [NV] = '{
    {8'h09, 3'd0, 16'h0000, 8'h62, 8'd8},  // R8 low fuse
    {8'h09, 3'd1, 16'h0001, 8'hFF, 8'd8},  // R8 lock byte, unprogrammed
    {8'h09, 3'd2, 16'h0002, 8'hF7, 8'd8},  // R8 extended fuse
    {8'h09, 3'd3, 16'h0003, 8'hD9, 8'd2},  // R2 last cycle of window
    {8'h09, 3'd4, 16'h0000, 8'hFF, 8'd2},  // R2 window expired -> plain read
    {8'h21, 3'd0, 16'h0000, 8'h3E, 8'd9},  // R9
    {8'h21, 3'd3, 16'h0001, 8'h5C, 8'd9},  // R9
    {8'h21, 3'd0, 16'h0002, 8'hA1, 8'd9},  // R9
    {8'h21, 3'd0, 16'h0003, 8'hFF, 8'd9},  // R9 unused index
    {8'h01, 3'd0, 16'h0004, 8'hFF, 8'd13}  // R13 fill command + load reads flash
  };

  initial begin
    logic [7:0] b;
    int n;
    @(negedge clk);
    @(negedge clk);
    // R14 reset state
    chk("R14 ctrl", 16'(ctrl_rdata), 16'h00);
    chk("R14 rdata", 16'(rdata), 16'h00);
    chk("R14 valid", 16'(rvalid), 16'h0);
    chk("R14 irq", 16'(irq), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      do_load(VEC[i][42:35], int'(VEC[i][34:32]), VEC[i][31:16], b);
      chk($sformatf("R%0d vector %0d", VEC[i][7:0], i), 16'(b), 16'(VEC[i][15:8]));
    end

    // R1 decode and readback
    arm(8'h07);
    chk("R1 invalid pattern", 16'(ctrl_rdata), 16'h00);
    arm(8'h05);
    chk("R1 write armed", 16'(ctrl_rdata), 16'h05);
    repeat (3) @(negedge clk);
    chk("R2 still armed cycle 4", 16'(ctrl_rdata), 16'h05);
    @(negedge clk);
    chk("R2 dropped after window", 16'(ctrl_rdata), 16'h00);

    // R3 fills, one too late
    do_store(8'h01, 0, 16'd16, 16'hA5C3);
    do_store(8'h01, 3, 16'd22, 16'h1234);
    do_store(8'h01, 4, 16'd20, 16'h7777);
    // R4 page write
    do_store(8'h05, 0, 16'd16, 16'h0000);
    wait_idle(n);
    chk("R4 write latency", 16'(n), 16'(WRITE_CYC));
    chk("R6 section busy set", 16'(ctrl_rdata[6]), 16'h1);
    plain_load(16'd16, b);
    chk("R6 read while busy", 16'(b), 16'hFF);
    do_store(8'h11, 0, 16'h0000, 16'h0000);
    chk("R6 re-enable clears", 16'(ctrl_rdata[6]), 16'h0);
    plain_load(16'd16, b); chk("R13 low byte", 16'(b), 16'hC3);
    plain_load(16'd17, b); chk("R13 high byte", 16'(b), 16'hA5);
    plain_load(16'd22, b); chk("R3 filled word", 16'(b), 16'h34);
    plain_load(16'd23, b); chk("R3 filled word hi", 16'(b), 16'h12);
    plain_load(16'd20, b); chk("R2 late fill dropped", 16'(b), 16'hFF);

    // R4 buffer cleared after commit
    do_store(8'h01, 0, 16'd34, 16'hBEEF);
    do_store(8'h05, 0, 16'd32, 16'h0000);
    wait_idle(n);
    do_store(8'h11, 0, 16'h0000, 16'h0000);
    plain_load(16'd32, b); chk("R4 buffer reset", 16'(b), 16'hFF);
    plain_load(16'd34, b); chk("R3 page2 word1", 16'(b), 16'hEF);

    // R11 page select out of range
    psel_we = 1'b1; psel = 8'h01;
    @(negedge clk);
    psel_we = 1'b0;
    plain_load(16'd34, b); chk("R11 out of range read", 16'(b), 16'hFF);
    do_store(8'h03, 0, 16'd34, 16'h0000);
    wait_idle(n);
    chk("R5 erase latency", 16'(n), 16'(ERASE_CYC));
    do_store(8'h11, 0, 16'h0000, 16'h0000);
    psel_we = 1'b1; psel = 8'h00;
    @(negedge clk);
    psel_we = 1'b0;
    plain_load(16'd34, b); chk("R11 array untouched", 16'(b), 16'hEF);

    // R10 irq, R12 busy-ignore, R5 erase
    arm(8'h80);
    chk("R10 irq idle", 16'(irq), 16'h1);
    do_store(8'h83, 0, 16'd16, 16'h0000);
    chk("R10 irq busy", 16'(irq), 16'h0);
    arm(8'h89);
    chk("R12 command held", 16'(ctrl_rdata), 16'hC3);
    wait_idle(n);
    chk("R10 irq after done", 16'(irq), 16'h1);
    do_store(8'h91, 0, 16'h0000, 16'h0000);
    plain_load(16'd16, b); chk("R5 erased low", 16'(b), 16'hFF);
    plain_load(16'd23, b); chk("R5 erased hi", 16'(b), 16'hFF);

    // R7 lock bits
    do_store(8'h09, 0, 16'h1234, 16'h00EF);
    do_load(8'h09, 0, 16'h0001, b);
    chk("R7 lock program", 16'(b), 16'hEF);
    do_store(8'h09, 1, 16'h0000, 16'h00DF);
    do_store(8'h09, 0, 16'h0000, 16'h00FF);
    do_load(8'h09, 2, 16'h0001, b);
    chk("R7 lock sticky", 16'(b), 16'hCF);

    summary();
    $finish;
  end
endmodule